// File: doc/BRIEF.md
# Dataflow Operand Matching Unit

This block executes a small static dataflow graph made of two-input instructions. It has no program counter. Each node of a 16-entry table holds one instruction and two operand slots, left and right. A token that arrives at a slot stores its value and marks the slot present. A node fires when every input it needs is present. Its result then travels as new tokens to at most two destination slots, and each destination is named inside the instruction as a node index plus a left/right selector.

The block is loaded through a write port that stores one instruction and one constant per cycle. An external port injects tokens into any slot. Each firing is reported on a registered output stream. Store nodes are terminal: their operand appears on a separate result port. Load nodes need no incoming token. Each one emits its constant once after it is programmed. A small unsigned integer ALU is included, and two sticky flags report slot collisions and division by zero.

Top module: `dfm_unit`

## Requirements
- R1: The instruction word has these fields: bits [2:0] opcode; bit 3 first-destination enable; bits [7:4] first-destination node; bit 8 first-destination port (0 left, 1 right); bit 9 second-destination enable; bits [13:10] second-destination node; bit 14 second-destination port. A write with `prog_we` stores the word and `prog_const` into node `prog_node` and clears both of that node's slots. A token aimed at that node in the same cycle is dropped.
- R2: An arithmetic node fires at the clock edge after the edge that made both of its slots present. The outputs `fire_valid`, `fire_node`, `fire_op` and `fire_result` are then valid for one cycle.
- R3: Opcode 0 adds, 1 subtracts (left minus right), 2 multiplies and 3 divides (left by right). All four are unsigned and modulo 2^32.
- R4: A division by zero gives a result of 0 and sets `err_div_zero`, which stays set until reset.
- R5: A firing node writes its result into each enabled destination slot at its firing edge. A destination completed this way fires at the next edge.
- R6: Firing clears the node's present marks, so the node needs fresh operands before it fires again.
- R7: At most one node fires per cycle. When several nodes are ready, the one with the lowest index fires first.
- R8: A node with opcode 4 (load) becomes armed when it is programmed. It fires once at the next edge, and its result is its constant.
- R9: A node with opcode 5 (store) fires when its left slot is present. It pulses `store_valid` with `store_node` and `store_data` (the left value) at the same time as the fire outputs, and it sends no tokens even if its destination enables are set.
- R10: A token that reaches a slot already present is dropped, and the slot keeps its old value. Two tokens that reach one empty slot in the same cycle leave one value stored. Either case sets `err_collision`, which stays set until reset.
- R11: After reset no slot is present, no node is armed, and `fire_valid`, `store_valid` and both error flags are low.
- R12: Opcodes 6 and 7 never fire, and a node that has not been programmed since reset never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Instruction write strobe |
| prog_node | input | 4 | Node written |
| prog_instr | input | 15 | Instruction word |
| prog_const | input | 32 | Constant used by load nodes |
| tok_valid | input | 1 | External token strobe |
| tok_node | input | 4 | Target node of the token |
| tok_port | input | 1 | Target slot, 0 left, 1 right |
| tok_data | input | 32 | Token value |
| fire_valid | output | 1 | A node fired at the last edge |
| fire_node | output | 4 | Index of the fired node |
| fire_op | output | 3 | Opcode of the fired node |
| fire_result | output | 32 | Value produced by the firing |
| store_valid | output | 1 | A store node fired |
| store_node | output | 4 | Index of the store node |
| store_data | output | 32 | Value taken by the store node |
| err_collision | output | 1 | Sticky slot collision flag |
| err_div_zero | output | 1 | Sticky division-by-zero flag |

## Verification
An external token lands in its slot at the edge that samples it. If that token completes a node, the node fires at the following edge. The fire outputs can therefore be read in the second cycle after the token was driven. A chained destination shows its firing exactly one cycle later, and each load node fires at the edge after the one that programmed it. The error flags change at the edge that causes them. The bench drives inputs and samples outputs on the falling clock edge, and it advances a fixed number of cycles before each comparison. The one exception is the graph test, which collects store results over a bounded window, because there the timing depends on arbitration.

// File: rtl/dfm_pkg.sv
package dfm_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_MUL   = 3'd2,
    OP_DIV   = 3'd3,
    OP_LOAD  = 3'd4,
    OP_STORE = 3'd5,
    OP_RSV_A = 3'd6,
    OP_RSV_B = 3'd7
  } op_e;

  // Field offsets of an instruction word, given the node index width.
  function automatic int unsigned d0_base();
    return 3;
  endfunction

  function automatic int unsigned d1_base(input int unsigned iw);
    return 3 + iw + 2;
  endfunction

endpackage

// File: rtl/dfm_alu.sv
module dfm_alu
  import dfm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          div_zero
);

  always_comb begin
    div_zero = 1'b0;
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = a * b;
      OP_DIV: begin
        if (b == '0) begin
          y        = '0;
          div_zero = 1'b1;
        end else begin
          y = a / b;
        end
      end
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/dfm_pick.sv
module dfm_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  // Walk from the top so the lowest requesting index is the last assignment.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/dfm_node_table.sv
module dfm_node_table
  import dfm_pkg::*;
#(
  parameter int NODES   = 16,
  parameter int DW      = 32,
  parameter int IW      = 4,
  parameter int INSTR_W = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prog_we,
  input  logic [IW-1:0]          prog_node,
  input  logic [INSTR_W-1:0]     prog_instr,
  input  logic [DW-1:0]          prog_const,
  // write requests: 0 first destination, 1 second destination, 2 external
  input  logic [2:0]             wr_vld,
  input  logic [2:0][IW-1:0]     wr_node,
  input  logic [2:0]             wr_port,
  input  logic [2:0][DW-1:0]     wr_data,
  input  logic                   fire_en,
  input  logic [IW-1:0]          fire_idx,
  output logic [NODES-1:0]       ready,
  output logic [INSTR_W-1:0]     ins_o   [NODES],
  output logic [DW-1:0]          cst_o   [NODES],
  output logic [DW-1:0]          opnd_o  [NODES][2],
  output logic                   coll_o
);

  localparam logic [INSTR_W-1:0] INS_RESET = {{(INSTR_W-3){1'b0}}, OP_RSV_B};

  logic [NODES-1:0][1:0] pres_all;
  logic [2*NODES-1:0]    coll_v;

  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic               prog_hit;
    logic               fire_hit;
    logic [INSTR_W-1:0] ins_q;
    logic [DW-1:0]      cst_q;
    logic               arm_q;
    logic               arm_d;
    logic [2:0]         op;

    assign prog_hit = prog_we && (prog_node == IW'(n));
    assign fire_hit = fire_en && (fire_idx == IW'(n));

    for (genvar s = 0; s < 2; s++) begin : g_slot
      logic [2:0]    hit;
      logic          pres_q;
      logic          pres_d;
      logic [DW-1:0] val_q;
      logic [DW-1:0] val_d;
      logic          val_we;
      logic          coll;

      always_comb begin
        for (int k = 0; k < 3; k++) begin
          hit[k] = wr_vld[k] && (wr_node[k] == IW'(n)) && (wr_port[k] == 1'(s));
        end
        pres_d = pres_q && !fire_hit;
        val_d  = val_q;
        val_we = 1'b0;
        coll   = 1'b0;
        if (prog_hit) begin
          pres_d = 1'b0;
        end else if (|hit) begin
          if (pres_d) begin
            coll = 1'b1;
          end else begin
            pres_d = 1'b1;
            val_we = 1'b1;
            val_d  = hit[0] ? wr_data[0] : (hit[1] ? wr_data[1] : wr_data[2]);
            coll   = (hit[0] & hit[1]) | (hit[0] & hit[2]) | (hit[1] & hit[2]);
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pres_q <= 1'b0;
        else        pres_q <= pres_d;
      end

      always_ff @(posedge clk) begin
        if (val_we) val_q <= val_d;
      end

      assign pres_all[n][s] = pres_q;
      assign opnd_o[n][s]   = val_q;
      assign coll_v[2*n+s]  = coll;
    end

    always_comb begin
      arm_d = arm_q && !fire_hit;
      if (prog_hit) arm_d = (prog_instr[2:0] == OP_LOAD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        arm_q <= 1'b0;
        ins_q <= INS_RESET;
      end else begin
        arm_q <= arm_d;
        if (prog_hit) ins_q <= prog_instr;
      end
    end

    always_ff @(posedge clk) begin
      if (prog_hit) cst_q <= prog_const;
    end

    assign op = ins_q[2:0];

    always_comb begin
      unique case (op)
        OP_ADD, OP_SUB, OP_MUL, OP_DIV: ready[n] = pres_all[n][0] & pres_all[n][1];
        OP_LOAD:                        ready[n] = arm_q;
        OP_STORE:                       ready[n] = pres_all[n][0];
        default:                        ready[n] = 1'b0;
      endcase
    end

    assign ins_o[n] = ins_q;
    assign cst_o[n] = cst_q;
  end

  assign coll_o = |coll_v;

endmodule

// File: rtl/dfm_unit.sv
module dfm_unit
  import dfm_pkg::*;
#(
  parameter  int NODES   = 16,
  parameter  int DW      = 32,
  localparam int IW      = $clog2(NODES),
  localparam int INSTR_W = 3 + 2 * (IW + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [IW-1:0]      prog_node,
  input  logic [INSTR_W-1:0] prog_instr,
  input  logic [DW-1:0]      prog_const,
  input  logic               tok_valid,
  input  logic [IW-1:0]      tok_node,
  input  logic               tok_port,
  input  logic [DW-1:0]      tok_data,
  output logic               fire_valid,
  output logic [IW-1:0]      fire_node,
  output logic [2:0]         fire_op,
  output logic [DW-1:0]      fire_result,
  output logic               store_valid,
  output logic [IW-1:0]      store_node,
  output logic [DW-1:0]      store_data,
  output logic               err_collision,
  output logic               err_div_zero
);

  localparam int D0 = d0_base();
  localparam int D1 = d1_base(IW);

  logic [NODES-1:0]   ready;
  logic [INSTR_W-1:0] ins   [NODES];
  logic [DW-1:0]      cst   [NODES];
  logic [DW-1:0]      opnd  [NODES][2];
  logic               coll;
  logic               fire_en;
  logic [IW-1:0]      fire_idx;

  logic [INSTR_W-1:0] sel_ins;
  logic [2:0]         sel_op;
  logic [DW-1:0]      opa;
  logic [DW-1:0]      opb;
  logic [DW-1:0]      alu_y;
  logic               alu_dz;
  logic [DW-1:0]      res;
  logic               is_store;

  logic [2:0]         wr_vld;
  logic [2:0][IW-1:0] wr_node;
  logic [2:0]         wr_port;
  logic [2:0][DW-1:0] wr_data;

  dfm_node_table #(
    .NODES(NODES), .DW(DW), .IW(IW), .INSTR_W(INSTR_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_we   (prog_we),
    .prog_node (prog_node),
    .prog_instr(prog_instr),
    .prog_const(prog_const),
    .wr_vld    (wr_vld),
    .wr_node   (wr_node),
    .wr_port   (wr_port),
    .wr_data   (wr_data),
    .fire_en   (fire_en),
    .fire_idx  (fire_idx),
    .ready     (ready),
    .ins_o     (ins),
    .cst_o     (cst),
    .opnd_o    (opnd),
    .coll_o    (coll)
  );

  dfm_pick #(.N(NODES), .IW(IW)) u_pick (
    .req(ready),
    .any(fire_en),
    .idx(fire_idx)
  );

  assign sel_ins  = ins[fire_idx];
  assign sel_op   = sel_ins[2:0];
  assign opa      = opnd[fire_idx][0];
  assign opb      = opnd[fire_idx][1];
  assign is_store = (sel_op == OP_STORE);

  dfm_alu #(.DW(DW)) u_alu (
    .op      (sel_op),
    .a       (opa),
    .b       (opb),
    .y       (alu_y),
    .div_zero(alu_dz)
  );

  always_comb begin
    unique case (sel_op)
      OP_LOAD:  res = cst[fire_idx];
      OP_STORE: res = opa;
      default:  res = alu_y;
    endcase
  end

  // Result tokens and the external token share the slot write network.
  always_comb begin
    wr_vld[0]  = fire_en && !is_store && sel_ins[D0];
    wr_node[0] = sel_ins[D0+1 +: IW];
    wr_port[0] = sel_ins[D0+1+IW];
    wr_data[0] = res;
    wr_vld[1]  = fire_en && !is_store && sel_ins[D1];
    wr_node[1] = sel_ins[D1+1 +: IW];
    wr_port[1] = sel_ins[D1+1+IW];
    wr_data[1] = res;
    wr_vld[2]  = tok_valid;
    wr_node[2] = tok_node;
    wr_port[2] = tok_port;
    wr_data[2] = tok_data;
  end

  // Output stage: next-state then registers.
  logic fv_d, sv_d, ec_d, ez_d;
  logic fv_q, sv_q, ec_q, ez_q;
  logic [IW-1:0] fn_q, sn_q;
  logic [2:0]    fo_q;
  logic [DW-1:0] fr_q, sd_q;

  always_comb begin
    fv_d = fire_en;
    sv_d = fire_en && is_store;
    ec_d = ec_q | coll;
    ez_d = ez_q | (fire_en && (sel_op == OP_DIV) && alu_dz);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_q <= 1'b0;
      sv_q <= 1'b0;
      ec_q <= 1'b0;
      ez_q <= 1'b0;
      fn_q <= '0;
      fo_q <= '0;
      sn_q <= '0;
    end else begin
      fv_q <= fv_d;
      sv_q <= sv_d;
      ec_q <= ec_d;
      ez_q <= ez_d;
      if (fire_en) begin
        fn_q <= fire_idx;
        fo_q <= sel_op;
      end
      if (sv_d) sn_q <= fire_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (fire_en) fr_q <= res;
    if (sv_d)    sd_q <= opa;
  end

  assign fire_valid    = fv_q;
  assign fire_node     = fn_q;
  assign fire_op       = fo_q;
  assign fire_result   = fr_q;
  assign store_valid   = sv_q;
  assign store_node    = sn_q;
  assign store_data    = sd_q;
  assign err_collision = ec_q;
  assign err_div_zero  = ez_q;

endmodule

// File: rtl/dfm_chk.sv
module dfm_chk #(
  parameter int NODES = 16,
  parameter int DW    = 32,
  parameter int IW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NODES-1:0] rdy,
  input logic             fire_valid,
  input logic [IW-1:0]    fire_node,
  input logic [2:0]       fire_op,
  input logic [DW-1:0]    fire_result,
  input logic             store_valid,
  input logic [IW-1:0]    store_node,
  input logic [DW-1:0]    store_data,
  input logic             err_collision,
  input logic             err_div_zero
);

  p_ready_fires_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rdy) |=> fire_valid);

  p_lowest_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_valid |-> ((($past(rdy) >> fire_node) & NODES'(1)) == NODES'(1)) &&
                   (($past(rdy) & ((NODES'(1) << fire_node) - NODES'(1))) == '0));

  p_store_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    store_valid |-> fire_valid && (fire_op == 3'd5) &&
                    (store_node == fire_node) && (store_data == fire_result));

  p_coll_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_collision |=> err_collision);

  p_dz_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_div_zero |=> err_div_zero);

  p_dz_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_div_zero) |-> fire_valid && (fire_op == 3'd3) && (fire_result == '0));

  p_inert_ops_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fire_valid |-> (fire_op < 3'd6));

endmodule

bind dfm_unit dfm_chk #(.NODES(NODES), .DW(DW), .IW(IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rdy          (ready),
  .fire_valid   (fire_valid),
  .fire_node    (fire_node),
  .fire_op      (fire_op),
  .fire_result  (fire_result),
  .store_valid  (store_valid),
  .store_node   (store_node),
  .store_data   (store_data),
  .err_collision(err_collision),
  .err_div_zero (err_div_zero)
);

// File: tb/tb_dfm_unit.sv
module tb_dfm_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_we;
  logic [3:0]  prog_node;
  logic [14:0] prog_instr;
  logic [31:0] prog_const;
  logic        tok_valid;
  logic [3:0]  tok_node;
  logic        tok_port;
  logic [31:0] tok_data;
  logic        fire_valid;
  logic [3:0]  fire_node;
  logic [2:0]  fire_op;
  logic [31:0] fire_result;
  logic        store_valid;
  logic [3:0]  store_node;
  logic [31:0] store_data;
  logic        err_collision;
  logic        err_div_zero;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dfm_unit dut (
    .clk(clk), .rst_n(rst_n),
    .prog_we(prog_we), .prog_node(prog_node), .prog_instr(prog_instr), .prog_const(prog_const),
    .tok_valid(tok_valid), .tok_node(tok_node), .tok_port(tok_port), .tok_data(tok_data),
    .fire_valid(fire_valid), .fire_node(fire_node), .fire_op(fire_op), .fire_result(fire_result),
    .store_valid(store_valid), .store_node(store_node), .store_data(store_data),
    .err_collision(err_collision), .err_div_zero(err_div_zero)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] mk(input logic [2:0] op,
                                     input logic e0, input logic [3:0] n0, input logic p0,
                                     input logic e1, input logic [3:0] n1, input logic p1);
    return {p1, n1, e1, p0, n0, e0, op};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; prog_we = 1'b0; tok_valid = 1'b0;
    prog_node = '0; prog_instr = '0; prog_const = '0;
    tok_node = '0; tok_port = 1'b0; tok_data = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic prog(input logic [3:0] n, input logic [14:0] ins, input logic [31:0] c);
    prog_we = 1'b1; prog_node = n; prog_instr = ins; prog_const = c;
    tick();
    prog_we = 1'b0;
  endtask

  task automatic tok(input logic [3:0] n, input logic p, input logic [31:0] d);
    tok_valid = 1'b1; tok_node = n; tok_port = p; tok_data = d;
    tick();
    tok_valid = 1'b0;
  endtask

  task automatic expect_fire(input string req, input logic [3:0] n, input logic [2:0] op, input logic [31:0] r);
    check(fire_valid && fire_node == n && fire_op == op && fire_result == r, req,
          {fire_valid, 3'b0, fire_node, 5'b0, fire_op, 16'b0} ^ fire_result,
          {1'b1, 3'b0, n, 5'b0, op, 16'b0} ^ r);
  endtask

  task automatic expect_idle(input string req);
    check(!fire_valid, req, 32'(fire_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] av [6];
    logic [31:0] bv [6];
    logic [31:0] e;
    logic [31:0] got9, got10;
    bit seen9, seen10;

    av[0] = 32'd7;          bv[0] = 32'd3;
    av[1] = 32'd0;          bv[1] = 32'd5;
    av[2] = 32'd3;          bv[2] = 32'd7;
    av[3] = 32'hFFFF_FFFF;  bv[3] = 32'd2;
    av[4] = 32'd100;        bv[4] = 32'd0;
    av[5] = 32'h0001_2345;  bv[5] = 32'h0000_1000;

    // R11: reset state
    do_reset();
    check(!fire_valid && !store_valid && !err_collision && !err_div_zero, "R11",
          {28'b0, fire_valid, store_valid, err_collision, err_div_zero}, 32'd0);

    // R2 R3: sweep every node, every arithmetic opcode, several operand pairs
    for (int n = 0; n < 16; n++) begin
      for (int op = 0; op < 4; op++) begin
        for (int k = 0; k < 6; k++) begin
          case (op)
            0: e = av[k] + bv[k];
            1: e = av[k] - bv[k];
            2: e = av[k] * bv[k];
            default: e = (bv[k] == 0) ? 32'd0 : av[k] / bv[k];
          endcase
          prog(4'(n), mk(3'(op), 0, 0, 0, 0, 0, 0), 32'd0);
          tok(4'(n), 1'b0, av[k]);
          tok(4'(n), 1'b1, bv[k]);
          expect_idle("R2 not before second edge");
          tick();
          expect_fire("R2 R3 sweep", 4'(n), 3'(op), e);
        end
      end
    end

    // R4: division by zero
    do_reset();
    check(!err_div_zero, "R4 clear", 32'(err_div_zero), 32'd0);
    prog(4'd4, mk(3'd3, 0, 0, 0, 0, 0, 0), 32'd0);
    tok(4'd4, 1'b0, 32'd9);
    tok(4'd4, 1'b1, 32'd0);
    tick();
    expect_fire("R4 zero result", 4'd4, 3'd3, 32'd0);
    check(err_div_zero, "R4 flag", 32'(err_div_zero), 32'd1);
    prog(4'd4, mk(3'd3, 0, 0, 0, 0, 0, 0), 32'd0);
    tok(4'd4, 1'b0, 32'd9);
    tok(4'd4, 1'b1, 32'd3);
    tick();
    expect_fire("R4 normal", 4'd4, 3'd3, 32'd3);
    check(err_div_zero, "R4 sticky", 32'(err_div_zero), 32'd1);

    // R5 R7 R8: a load feeds two nodes that become ready together
    do_reset();
    prog(4'd5, mk(3'd0, 0, 0, 0, 0, 0, 0), 32'd0);
    prog(4'd12, mk(3'd0, 0, 0, 0, 0, 0, 0), 32'd0);
    tok(4'd5, 1'b0, 32'd10);
    tok(4'd12, 1'b0, 32'd20);
    prog(4'd0, mk(3'd4, 1, 4'd12, 1, 1, 4'd5, 1), 32'd7);
    tick();
    expect_fire("R8 load fires", 4'd0, 3'd4, 32'd7);
    tick();
    expect_fire("R7 lower index first", 4'd5, 3'd0, 32'd17);
    tick();
    expect_fire("R5 second destination", 4'd12, 3'd0, 32'd27);
    tick();
    expect_idle("R8 load fires once");
    tick();
    expect_idle("R8 load fires once");

    // R6: presence cleared after firing
    tok(4'd5, 1'b0, 32'd1);
    tick();
    expect_idle("R6 one operand only");
    tok(4'd5, 1'b1, 32'd2);
    tick();
    expect_fire("R6 fresh operands", 4'd5, 3'd0, 32'd3);

    // R1: reprogramming clears slots
    prog(4'd6, mk(3'd0, 0, 0, 0, 0, 0, 0), 32'd0);
    tok(4'd6, 1'b0, 32'd4);
    prog(4'd6, mk(3'd0, 0, 0, 0, 0, 0, 0), 32'd0);
    tok(4'd6, 1'b1, 32'd5);
    tick();
    expect_idle("R1 slot cleared");
    tick();
    expect_idle("R1 slot cleared");
    tok(4'd6, 1'b0, 32'd1);
    tick();
    expect_fire("R1 refilled", 4'd6, 3'd0, 32'd6);

    // R9: store reports and sends nothing
    do_reset();
    prog(4'd2, mk(3'd0, 0, 0, 0, 0, 0, 0), 32'd0);
    prog(4'd9, mk(3'd5, 1, 4'd2, 0, 1, 4'd2, 0), 32'd0);
    tok(4'd2, 1'b1, 32'd100);
    tok(4'd9, 1'b0, 32'd55);
    tick();
    check(store_valid && store_node == 4'd9 && store_data == 32'd55, "R9 store output",
          store_data, 32'd55);
    expect_fire("R9 store fire", 4'd9, 3'd5, 32'd55);
    tick();
    expect_idle("R9 no token sent");
    check(!store_valid, "R9 store pulse", 32'(store_valid), 32'd0);
    tick();
    expect_idle("R9 no token sent");

    // R10: collision on an occupied slot
    do_reset();
    check(!err_collision, "R10 clear", 32'(err_collision), 32'd0);
    prog(4'd7, mk(3'd0, 0, 0, 0, 0, 0, 0), 32'd0);
    tok(4'd7, 1'b0, 32'd5);
    tok(4'd7, 1'b0, 32'd9);
    check(err_collision, "R10 flag", 32'(err_collision), 32'd1);
    tok(4'd7, 1'b1, 32'd1);
    tick();
    expect_fire("R10 old value kept", 4'd7, 3'd0, 32'd6);
    check(err_collision, "R10 sticky", 32'(err_collision), 32'd1);

    // R10: two tokens into one empty slot in the same cycle
    do_reset();
    prog(4'd3, mk(3'd0, 0, 0, 0, 0, 0, 0), 32'd0);
    prog(4'd1, mk(3'd4, 1, 4'd3, 0, 1, 4'd3, 0), 32'd11);
    tick();
    check(err_collision, "R10 same-cycle", 32'(err_collision), 32'd1);
    tok(4'd3, 1'b1, 32'd4);
    tick();
    expect_fire("R10 one value stored", 4'd3, 3'd0, 32'd15);

    // R12: reserved opcodes and unprogrammed nodes stay quiet
    do_reset();
    prog(4'd8, mk(3'd6, 0, 0, 0, 0, 0, 0), 32'd0);
    tok(4'd8, 1'b0, 32'd1);
    tok(4'd8, 1'b1, 32'd2);
    tick();
    expect_idle("R12 reserved opcode");
    prog(4'd8, mk(3'd7, 0, 0, 0, 0, 0, 0), 32'd0);
    tok(4'd8, 1'b0, 32'd1);
    tick();
    expect_idle("R12 reserved opcode");
    tok(4'd13, 1'b0, 32'd1);
    tok(4'd13, 1'b1, 32'd2);
    tick();
    expect_idle("R12 unprogrammed");

    // R5 R9: small expression graph (X+Y)*(A+B) and (X-Y)/(A+B)
    do_reset();
    prog(4'd4,  mk(3'd0, 1, 4'd7, 1, 1, 4'd8, 1), 32'd0);
    prog(4'd5,  mk(3'd0, 1, 4'd7, 0, 0, 0, 0), 32'd0);
    prog(4'd6,  mk(3'd1, 1, 4'd8, 0, 0, 0, 0), 32'd0);
    prog(4'd7,  mk(3'd2, 1, 4'd9, 0, 0, 0, 0), 32'd0);
    prog(4'd8,  mk(3'd3, 1, 4'd10, 0, 0, 0, 0), 32'd0);
    prog(4'd9,  mk(3'd5, 0, 0, 0, 0, 0, 0), 32'd0);
    prog(4'd10, mk(3'd5, 0, 0, 0, 0, 0, 0), 32'd0);
    seen9 = 1'b0; seen10 = 1'b0; got9 = '0; got10 = '0;
    prog(4'd0, mk(3'd4, 1, 4'd4, 0, 0, 0, 0), 32'd6);
    prog(4'd1, mk(3'd4, 1, 4'd4, 1, 0, 0, 0), 32'd2);
    prog(4'd2, mk(3'd4, 1, 4'd5, 0, 1, 4'd6, 0), 32'd20);
    prog(4'd3, mk(3'd4, 1, 4'd5, 1, 1, 4'd6, 1), 32'd4);
    for (int c = 0; c < 30; c++) begin
      if (store_valid && store_node == 4'd9)  begin seen9 = 1'b1;  got9 = store_data;  end
      if (store_valid && store_node == 4'd10) begin seen10 = 1'b1; got10 = store_data; end
      tick();
    end
    check(seen9 && got9 == 32'd192, "R5 graph product", got9, 32'd192);
    check(seen10 && got10 == 32'd2, "R9 graph quotient", got10, 32'd2);
    check(!err_collision && !err_div_zero, "R10 graph clean",
          {30'b0, err_collision, err_div_zero}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule